// File: doc/BRIEF.md
# Four-Level Prioritised Interrupt Controller

This block gathers a wide set of interrupt request lines, each given a 2-bit priority level and an enable bit. For each of the four levels it finds the lowest-numbered enabled and pending source. The highest level that has anything pending wins. That level is compared with a 2-bit mask taken from the core's status register. When delivery is allowed and the controller is enabled, the block raises a request toward the core and presents the winning source number as the vector. The request and vector stay held until the core acknowledges.

Two of the sources are external active-low pins. Each pin can be set to detect a falling edge, which is latched as a sticky pending flag, or to follow the pin level. In low-power mode both pins always follow the pin level, because no edge can be detected without a clock. In low-power mode a wake request is raised for any pending source whose enable was already set before low-power mode was entered.

The delivery sequencer has three states. `ST_IDLE` waits for an allowed winner. `ST_REQ` drives the request with the vector held. `ST_DONE` is a one-cycle gap after an acknowledge, during which the sticky flag of the acknowledged source is seen cleared. The transitions are:
- `T_RAISE` (IDLE→REQ): the controller is enabled and an allowed winner exists.
- `T_ACK` (REQ→DONE): acknowledge.
- `T_WITHDRAW` (REQ→IDLE): the controller enable drops.
- `T_REARM` (DONE→IDLE): always, after one cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_req, irq_vec, irq_lvl and wake_req are all 0.
- R2: Among pending enabled sources of the same level, the lowest source index is reported as irq_vec.
- R3: Level 3 beats level 2, level 2 beats level 1, and level 1 beats level 0. Each source's level is src_lvl[2*i+1:2*i].
- R4: A winner is delivered only when its level is greater than or equal to sr_mask. Level 3 is always delivered.
- R5: A source whose src_en bit is 0 never causes a request.
- R6: While ctrl_en is 0 no request is raised. If ctrl_en falls during a request, irq_req is 0 from the next cycle.
- R7: irq_req rises one clock edge after an allowed winner appears. irq_vec and irq_lvl are captured at that edge and held until iack. On iack irq_req drops at the next edge and stays low for one cycle before it can rise again.
- R8: With ext_edge[k]=1 outside low-power mode, a 1-to-0 transition on the pin sets a pending flag that stays set after the pin returns high. Only an acknowledge naming that source clears it. A pin held low without a transition is not pending. Pin A is source 0 (bit 0) and pin B is source 1 (bit 1).
- R9: With ext_edge[k]=0, the external source is pending exactly while its pin is low.
- R10: While lowpwr is 1, both external sources are pending while their pin is low, whatever ext_edge selects, and no edge is latched.
- R11: wake_req is 1 only while lowpwr is 1 and some source is pending whose src_en bit was set at the last clock edge before lowpwr rose. Enables set during low-power mode do not wake.
- R12: The src_req bits at the two external source indices are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Global controller enable |
| lowpwr | input | 1 | Wait/stop mode indication |
| src_req | input | NUM_SRC | Internal source requests, active high |
| src_en | input | NUM_SRC | Per-source enable |
| src_lvl | input | 2*NUM_SRC | Per-source 2-bit level |
| ext_a_n | input | 1 | External pin A, active low |
| ext_b_n | input | 1 | External pin B, active low |
| ext_edge | input | 2 | Per-pin falling-edge select (bit 0 pin A) |
| sr_mask | input | 2 | Core interrupt mask from status bits 9:8 |
| iack | input | 1 | Interrupt acknowledge from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | SRC_W | Winning source number |
| irq_lvl | output | 2 | Level of the delivered source |
| wake_req | output | 1 | Wake request toward clock control |

## Verification
The bench builds the block with its default of 82 sources, with the pins at indices 0 and 1. At that size the encoders run across their full width, so winners near index 81 and ties among many sources in one level are reached by the random trials. Keeping the pins at the lowest indices lets the directed cases show pin requests winning within a level, and lets them check that the internal request bits at those indices are ignored.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 4;
    localparam int NUM_EXT = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } pic_state_e;

endpackage

// File: rtl/pic_ext_cond.sv
module pic_ext_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic lowpwr,
    input  logic ack_hit,
    output logic pend
);

    logic prev_q;
    logic sticky_q;
    logic fall;

    // edge detection only possible while clocks run normally
    assign fall = edge_mode & ~lowpwr & prev_q & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b1;
            sticky_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (fall) begin
                sticky_q <= 1'b1;
            end else if (ack_hit || !edge_mode) begin
                sticky_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (lowpwr || !edge_mode) begin
            pend = ~pin_n;
        end else begin
            pend = sticky_q | fall;
        end
    end

endmodule

// File: rtl/pic_lvl_enc.sv
module pic_lvl_enc #(
    parameter int NUM_SRC = 82,
    parameter int SRC_W   = 7
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [SRC_W-1:0]   num
);

    always_comb begin
        num = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                num = SRC_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/pic_lvl_pick.sv
module pic_lvl_pick
    import pic_pkg::*;
#(
    parameter int SRC_W = 7
) (
    input  logic [NUM_LVL-1:0]            any,
    input  logic [NUM_LVL-1:0][SRC_W-1:0] nums,
    output logic                          valid,
    output logic [LVL_W-1:0]              lvl,
    output logic [SRC_W-1:0]              num
);

    always_comb begin
        valid = 1'b0;
        lvl   = '0;
        num   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (any[l]) begin
                valid = 1'b1;
                lvl   = LVL_W'(l);
                num   = nums[l];
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC   = 82,
    parameter int EXT_A_IDX = 0,
    parameter int EXT_B_IDX = 1,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_en,
    input  logic                     lowpwr,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [LVL_W*NUM_SRC-1:0] src_lvl,
    input  logic                     ext_a_n,
    input  logic                     ext_b_n,
    input  logic [NUM_EXT-1:0]       ext_edge,
    input  logic [LVL_W-1:0]         sr_mask,
    input  logic                     iack,
    output logic                     irq_req,
    output logic [SRC_W-1:0]         irq_vec,
    output logic [LVL_W-1:0]         irq_lvl,
    output logic                     wake_req
);

    pic_state_e state_q, state_d;

    logic [SRC_W-1:0]   vec_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [NUM_SRC-1:0] en_snap_q;

    logic [NUM_EXT-1:0] ext_pin_n;
    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_SRC-1:0] raw_pend;
    logic [NUM_SRC-1:0] qual;

    logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_req;
    logic [NUM_LVL-1:0]              lvl_any;
    logic [NUM_LVL-1:0][SRC_W-1:0]   lvl_num;

    logic             win_valid;
    logic [LVL_W-1:0] win_lvl;
    logic [SRC_W-1:0] win_num;
    logic             allowed;
    logic             take;

    assign ext_pin_n = {ext_b_n, ext_a_n};

    // external pin conditioning
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        localparam int IDX = (g == 0) ? EXT_A_IDX : EXT_B_IDX;
        logic ack_hit;
        assign ack_hit = (state_q == ST_REQ) && iack && (vec_q == SRC_W'(IDX));
        pic_ext_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[g]),
            .edge_mode (ext_edge[g]),
            .lowpwr    (lowpwr),
            .ack_hit   (ack_hit),
            .pend      (ext_pend[g])
        );
    end

    always_comb begin
        raw_pend            = src_req;
        raw_pend[EXT_A_IDX] = ext_pend[0];
        raw_pend[EXT_B_IDX] = ext_pend[1];
        qual                = raw_pend & src_en;
    end

    // level membership decode
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_req[l][i] = qual[i] && (src_lvl[LVL_W*i +: LVL_W] == LVL_W'(l));
            end
        end
    end

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_enc
        pic_lvl_enc #(
            .NUM_SRC (NUM_SRC),
            .SRC_W   (SRC_W)
        ) u_enc (
            .req (lvl_req[l]),
            .any (lvl_any[l]),
            .num (lvl_num[l])
        );
    end

    pic_lvl_pick #(
        .SRC_W (SRC_W)
    ) u_pick (
        .any   (lvl_any),
        .nums  (lvl_num),
        .valid (win_valid),
        .lvl   (win_lvl),
        .num   (win_num)
    );

    assign allowed = win_valid && ((win_lvl >= sr_mask) || (win_lvl == 2'd3));
    assign take    = ctrl_en && allowed;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)          state_d = ST_REQ;   // T_RAISE
            ST_REQ: begin
                if (!ctrl_en)           state_d = ST_IDLE;  // T_WITHDRAW
                else if (iack)          state_d = ST_DONE;  // T_ACK
            end
            ST_DONE:                    state_d = ST_IDLE;  // T_REARM
            default:                    state_d = ST_IDLE;
        endcase
    end

    // vector capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= '0;
        end else if (state_q == ST_IDLE && take) begin
            vec_q <= win_num;
            lvl_q <= win_lvl;
        end
    end

    // enables frozen on entry to low power
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_snap_q <= '0;
        end else if (!lowpwr) begin
            en_snap_q <= src_en;
        end
    end

    // outputs
    always_comb begin
        irq_req  = (state_q == ST_REQ);
        irq_vec  = vec_q;
        irq_lvl  = lvl_q;
        wake_req = lowpwr && |(raw_pend & en_snap_q);
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int SRC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             lowpwr,
    input logic             iack,
    input logic [1:0]       sr_mask,
    input logic             irq_req,
    input logic [SRC_W-1:0] irq_vec,
    input logic [1:0]       irq_lvl,
    input logic             wake_req
);

    AST_WAKE_IN_LP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> lowpwr); // R11

    AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !irq_req); // R6

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(irq_req)) |-> ($stable(irq_vec) && $stable(irq_lvl))); // R7

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && iack) |=> !irq_req); // R7

    AST_RISE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ((irq_lvl >= $past(sr_mask)) || (irq_lvl == 2'd3))); // R4

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en),
    .lowpwr   (lowpwr),
    .iack     (iack),
    .sr_mask  (sr_mask),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_lvl  (irq_lvl),
    .wake_req (wake_req)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 82;
    localparam int VW         = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_en = 1'b1;
    logic              lowpwr = 1'b0;
    logic [NS-1:0]     src_req = '0;
    logic [NS-1:0]     src_en = '0;
    logic [2*NS-1:0]   src_lvl = '0;
    logic              ext_a_n = 1'b1;
    logic              ext_b_n = 1'b1;
    logic [1:0]        ext_edge = 2'b00;
    logic [1:0]        sr_mask = 2'b00;
    logic              iack = 1'b0;
    logic              irq_req;
    logic [VW-1:0]     irq_vec;
    logic [1:0]        irq_lvl;
    logic              wake_req;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .lowpwr(lowpwr),
        .src_req(src_req), .src_en(src_en), .src_lvl(src_lvl),
        .ext_a_n(ext_a_n), .ext_b_n(ext_b_n), .ext_edge(ext_edge),
        .sr_mask(sr_mask), .iack(iack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {allow, lvl, vec}
    function automatic logic [9:0] model(input logic [NS-1:0] p, input logic [NS-1:0] en,
                                         input logic [2*NS-1:0] lv, input logic [1:0] m);
        for (int l = 3; l >= 0; l--) begin
            for (int i = 0; i < NS; i++) begin
                if (p[i] && en[i] && lv[2*i +: 2] == 2'(l)) begin
                    return {(2'(l) >= m) || (l == 3), 2'(l), 7'(i)};
                end
            end
        end
        return '0;
    endfunction

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_lvl(input int i, input logic [1:0] l);
        src_lvl[2*i +: 2] = l;
    endtask

    task automatic cleanup();
        src_req  = '0;
        ext_a_n  = 1'b1;
        ext_b_n  = 1'b1;
        lowpwr   = 1'b0;
        ctrl_en  = 1'b1;
        iack     = irq_req;
        cyc(1);
        iack     = 1'b0;
        ext_edge = 2'b00;
        cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [9:0] e;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        @(negedge clk);
        check("R1 req", irq_req, 0);
        check("R1 vec", irq_vec, 0);
        check("R1 lvl", irq_lvl, 0);
        check("R1 wake", wake_req, 0);
        rst_n = 1'b1;
        src_en = '1;
        cyc(1);

        // R2: same level, lowest index wins
        for (int i = 0; i < NS; i++) set_lvl(i, 2'd1);
        src_req[70] = 1; src_req[40] = 1; src_req[10] = 1;
        cyc(1);
        check("R2 req", irq_req, 1);
        check("R2 vec", irq_vec, 10);
        cleanup();

        // R3: higher level wins
        set_lvl(5, 2'd0); set_lvl(60, 2'd2);
        src_req[5] = 1; src_req[60] = 1;
        cyc(1);
        check("R3 vec", irq_vec, 60);
        check("R3 lvl", irq_lvl, 2);
        cleanup();

        // R4: mask
        sr_mask = 2'd2; set_lvl(20, 2'd1); src_req[20] = 1;
        cyc(1);
        check("R4 masked", irq_req, 0);
        cleanup();
        sr_mask = 2'd3; set_lvl(21, 2'd3); src_req[21] = 1;
        cyc(1);
        check("R4 level3 passes", irq_req, 1);
        check("R4 vec", irq_vec, 21);
        cleanup();
        sr_mask = 2'd0;

        // R5: disabled source
        src_en[33] = 0; src_req[33] = 1;
        cyc(2);
        check("R5 disabled", irq_req, 0);
        cleanup();
        src_en = '1;

        // R6: global enable
        ctrl_en = 0; src_req[44] = 1;
        cyc(2);
        check("R6 blocked", irq_req, 0);
        ctrl_en = 1;
        cyc(1);
        check("R6 raised", irq_req, 1);
        ctrl_en = 0;
        cyc(1);
        check("R6 withdrawn", irq_req, 0);
        cleanup();

        // R12: src_req at pin indices ignored
        src_req[0] = 1; src_req[1] = 1;
        cyc(2);
        check("R12 ignored", irq_req, 0);
        cleanup();

        // R9: level-mode pin B
        ext_b_n = 0;
        cyc(1);
        check("R9 pin low", irq_req, 1);
        check("R9 vec", irq_vec, 1);
        cleanup();
        cyc(1);
        check("R9 pin high", irq_req, 0);

        // R7: hold and re-arm
        set_lvl(30, 2'd1); set_lvl(3, 2'd3);
        src_req[30] = 1;
        cyc(1);
        check("R7 first vec", irq_vec, 30);
        src_req[3] = 1;
        cyc(1);
        check("R7 held vec", irq_vec, 30);
        check("R7 held lvl", irq_lvl, 1);
        iack = 1;
        cyc(1);
        iack = 0;
        check("R7 drop", irq_req, 0);
        cyc(1);
        check("R7 gap", irq_req, 0);
        cyc(1);
        check("R7 rearm", irq_req, 1);
        check("R7 new vec", irq_vec, 3);
        cleanup();

        // R8: sticky falling edge on pin A
        ext_edge = 2'b01; ctrl_en = 0;
        cyc(1);
        ext_a_n = 0;
        cyc(1);
        ext_a_n = 1;
        cyc(2);
        ctrl_en = 1;
        cyc(1);
        check("R8 sticky req", irq_req, 1);
        check("R8 vec", irq_vec, 0);
        iack = 1;
        cyc(1);
        iack = 0;
        cyc(3);
        check("R8 cleared by ack", irq_req, 0);

        // R10: low power makes pin level sensitive; no edge latched
        ctrl_en = 0;
        lowpwr = 1; ext_a_n = 0;
        cyc(1);
        check("R10 wake on low pin", wake_req, 1);
        lowpwr = 0;
        cyc(1);
        check("R10 no wake out of lp", wake_req, 0);
        ctrl_en = 1;
        cyc(2);
        check("R8 held low no edge", irq_req, 0);
        cleanup();

        // R11: enable snapshot
        ctrl_en = 0;
        src_en[5] = 0; src_en[7] = 1;
        cyc(1);
        lowpwr = 1; src_en[5] = 1; src_req[5] = 1;
        cyc(1);
        check("R11 late enable no wake", wake_req, 0);
        src_req[7] = 1;
        #1;
        check("R11 wake", wake_req, 1);
        cleanup();
        src_en = '1;

        // random trials
        for (int t = 0; t < 60; t++) begin
            for (int i = 2; i < NS; i++) src_req[i] = ($urandom_range(0, 7) == 0);
            for (int i = 0; i < NS; i++) begin
                src_en[i] = ($urandom_range(0, 3) != 0);
                set_lvl(i, (t % 4 == 0) ? 2'd2 : 2'($urandom_range(0, 3)));
            end
            sr_mask = 2'($urandom_range(0, 3));
            e = model(src_req & ~82'b11, src_en, src_lvl, sr_mask);
            cyc(1);
            check("R4 random req", irq_req, e[9]);
            if (e[9]) begin
                check("R2 R3 random vec", irq_vec, e[6:0]);
                check("R3 random lvl", irq_lvl, e[8:7]);
            end
            cleanup();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule